// File: doc/BRIEF.md
# Pixel Hit Latency and Trigger Buffer

This block is the digital back end of a single pixel cell. A hit from the discriminator, or a test pulse when test injection is enabled, has to be held for a fixed trigger latency. No shift register is used. Instead, one of two delay units latches the current value of a shared, periodic, Gray-coded time-stamp bus. The unit releases the hit when the bus comes back round to that same value, so the latency equals the period of the bus pattern.

On the cycle a delay unit releases, a coincidence stage compares the hit with the trigger strobe. A small event buffer is written on every trigger cycle. The stored bit is 1 when a held hit expires in that cycle and 0 otherwise. The write location and the read location come from externally supplied Gray-coded address busses that are shared across many cells, and a read strobe loads the addressed entry into the cell's single output bit.

Top module: `pix_hit_buffer`

## Requirements
- R1: A hit presented in cycle c and captured at the following edge is seen as expiring in cycle c+P, where P is the period of the time-stamp bus. A trigger high in cycle c+P therefore stores 1.
- R2: A trigger one cycle before or one cycle after the expiry cycle stores 0 for that event. The hit is discarded when it expires without a trigger.
- R3: Two hits in different cycles within one latency window are both held, each by its own delay unit, and each is delivered at its own expiry. At most one unit captures per cycle, and the lowest-index free unit wins.
- R4: A hit that arrives while both delay units are busy is dropped, and the overflow output goes high and stays high until reset.
- R5: While the mask bit is high, neither a discriminator hit nor a test pulse is captured.
- R6: A test pulse injects a hit only while the test-enable bit is high. With test-enable low it has no effect.
- R7: Every cycle with the trigger high writes one buffer entry, at the location given by the Gray write address. The codes 00, 01, 11 and 10 select locations 0, 1, 2 and 3. No entry changes in a cycle without the trigger.
- R8: On a cycle with the read strobe high, the output takes the entry at the Gray read address, using the same code mapping as R7, at the next edge. Without the strobe the output holds its value.
- R9: Reset clears both delay units, all buffer entries, the output bit and the overflow flag.
- R10: A delay unit is still busy in its expiry cycle and can capture a new hit in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rstN | input | 1 | Active-low synchronous reset |
| discHit | input | 1 | Discriminator hit |
| testPulse | input | 1 | Test injection pulse |
| cfgMask | input | 1 | Mask bit; blocks all hits when high |
| cfgTestEn | input | 1 | Enables the test pulse as a hit source |
| stampBus | input | STAMP_W | Shared periodic Gray-coded time stamp |
| trigger | input | 1 | Trigger strobe, sampled at expiry |
| wrAddr | input | ADDR_W | Gray-coded buffer write location |
| rdAddr | input | ADDR_W | Gray-coded buffer read location |
| readStrobe | input | 1 | Loads the addressed entry into hitOut |
| hitOut | output | 1 | Hit bit of the selected event |
| ovfFlag | output | 1 | Sticky flag: a hit was lost, both units busy |

## Verification
Some properties are checked on every cycle by the assertions: the overflow flag never falls, the count of busy delay units never rises while the cell is masked, no more than one unit captures in a cycle, no buffer entry changes without a trigger, and the output holds when no read strobe is given. The latency itself, the exact trigger coincidence (early, on time, late), the pairing of two hits in one window, unit reuse right after expiry, and the Gray address mapping depend on whole sequences of cycles. Only the bench's scenarios can show these, by comparing buffer contents against its own model of the two delay units.

// File: rtl/pix_hit_pkg.sv
`timescale 1ns/1ps
package pix_hit_pkg;
  // strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic wrEn;   // write an event entry this cycle
    logic wrBit;  // value written: a held hit expired this cycle
    logic rdEn;   // load the addressed entry into the output bit
  } cellStrobe_t;
endpackage

// File: rtl/pix_hit_ctrl.sv
`timescale 1ns/1ps
module pix_hit_ctrl
  import pix_hit_pkg::*;
#(
  parameter int UNITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitIn,
  input  logic             trigger,
  input  logic             readStrobe,
  input  logic [UNITS-1:0] match,
  output logic [UNITS-1:0] capture,
  output logic [UNITS-1:0] busyVec,
  output cellStrobe_t      strb,
  output logic             ovfFlag
);
  logic [UNITS-1:0] busyQ;
  logic [UNITS-1:0] expire;
  logic             taken;

  always_comb begin
    expire  = busyQ & match;
    capture = '0;
    taken   = 1'b0;
    // lowest free unit takes the hit; a unit expiring now is not yet free
    for (int i = 0; i < UNITS; i++) begin
      if (hitIn && !busyQ[i] && !taken) begin
        capture[i] = 1'b1;
        taken      = 1'b1;
      end
    end
    strb.wrEn  = trigger;
    strb.wrBit = |expire;
    strb.rdEn  = readStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      busyQ   <= (busyQ & ~expire) | capture;
      ovfFlag <= ovfFlag | (hitIn & ~taken);
    end
  end

  assign busyVec = busyQ;
endmodule

// File: rtl/pix_hit_dpath.sv
`timescale 1ns/1ps
module pix_hit_dpath
  import pix_hit_pkg::*;
#(
  parameter int STAMP_W = 8,
  parameter int UNITS   = 2,
  parameter int DEPTH   = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STAMP_W-1:0] stampBus,
  input  logic [UNITS-1:0]   capture,
  input  cellStrobe_t        strb,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [UNITS-1:0]   match,
  output logic [DEPTH-1:0]   memVec,
  output logic               hitOut
);
  function automatic logic [ADDR_W-1:0] grayToBin(input logic [ADDR_W-1:0] g);
    logic [ADDR_W-1:0] b;
    b[ADDR_W-1] = g[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // one latched time stamp per delay unit
  for (genvar u = 0; u < UNITS; u++) begin : gUnit
    logic [STAMP_W-1:0] stampQ;
    always_ff @(posedge clk) begin
      if (!rstN)           stampQ <= '0;
      else if (capture[u]) stampQ <= stampBus;
    end
    assign match[u] = (stampQ == stampBus);
  end

  logic [DEPTH-1:0] memQ;
  always_ff @(posedge clk) begin
    if (!rstN)          memQ <= '0;
    else if (strb.wrEn) memQ[grayToBin(wrAddr)] <= strb.wrBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          hitOut <= 1'b0;
    else if (strb.rdEn) hitOut <= memQ[grayToBin(rdAddr)];
  end

  assign memVec = memQ;
endmodule

// File: rtl/pix_hit_buffer.sv
`timescale 1ns/1ps
module pix_hit_buffer
  import pix_hit_pkg::*;
#(
  parameter int STAMP_W = 8,
  parameter int UNITS   = 2,
  parameter int DEPTH   = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               discHit,
  input  logic               testPulse,
  input  logic               cfgMask,
  input  logic               cfgTestEn,
  input  logic [STAMP_W-1:0] stampBus,
  input  logic               trigger,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               readStrobe,
  output logic               hitOut,
  output logic               ovfFlag
);
  logic             hitIn;
  logic [UNITS-1:0] match;
  logic [UNITS-1:0] capture;
  logic [UNITS-1:0] busyVec;
  logic [DEPTH-1:0] memVec;
  cellStrobe_t      strb;

  assign hitIn = (discHit | (testPulse & cfgTestEn)) & ~cfgMask;

  pix_hit_ctrl #(.UNITS(UNITS)) ctrl (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .trigger(trigger),
    .readStrobe(readStrobe), .match(match), .capture(capture),
    .busyVec(busyVec), .strb(strb), .ovfFlag(ovfFlag)
  );

  pix_hit_dpath #(.STAMP_W(STAMP_W), .UNITS(UNITS), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .stampBus(stampBus), .capture(capture),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .match(match),
    .memVec(memVec), .hitOut(hitOut)
  );
endmodule

// File: rtl/pix_hit_buffer_chk.sv
`timescale 1ns/1ps
module pix_hit_buffer_chk #(
  parameter int UNITS = 2,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgMask,
  input logic             trigger,
  input logic             readStrobe,
  input logic             hitOut,
  input logic             ovfFlag,
  input logic [UNITS-1:0] busyVec,
  input logic [DEPTH-1:0] memVec
);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  // R5
  mask_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgMask |=> ($countones(busyVec) <= $countones($past(busyVec))));

  // R3
  single_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0(busyVec & ~$past(busyVec)));

  // R7
  write_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trigger |=> $stable(memVec));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> $stable(hitOut));
endmodule

bind pix_hit_buffer pix_hit_buffer_chk #(.UNITS(UNITS), .DEPTH(DEPTH)) chkInst (
  .clk(clk), .rstN(rstN), .cfgMask(cfgMask), .trigger(trigger),
  .readStrobe(readStrobe), .hitOut(hitOut), .ovfFlag(ovfFlag),
  .busyVec(busyVec), .memVec(memVec)
);

// File: tb/tb_pix_hit_buffer.sv
`timescale 1ns/1ps
module tb_pix_hit_buffer;
  localparam int PERIOD = 16;   // steps of the Gray time-stamp pattern
  localparam int NUNITS = 2;
  localparam int RUNLEN = 2 * PERIOD + 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       discHit = 1'b0, testPulse = 1'b0, cfgMask = 1'b0, cfgTestEn = 1'b0;
  logic [7:0] stampBus = '0;
  logic       trigger = 1'b0, readStrobe = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic       hitOut, ovfFlag;

  int  checks = 0, errors = 0;
  bit  finished = 1'b0;
  logic [3:0] stampCnt = '0;

  int  hitAt[4];
  int  trigAt[4];
  int  nHits, nTrig;
  bit  useTest, testEnOn, maskOn, expOvf;
  bit  expBit[4];

  pix_hit_buffer dut (
    .clk(clk), .rstN(rstN), .discHit(discHit), .testPulse(testPulse),
    .cfgMask(cfgMask), .cfgTestEn(cfgTestEn), .stampBus(stampBus),
    .trigger(trigger), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .readStrobe(readStrobe), .hitOut(hitOut), .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  // shared periodic Gray time stamp, one step per cycle
  always @(negedge clk) begin
    stampCnt <= stampCnt + 4'd1;
    stampBus <= {4'b0, stampCnt ^ (stampCnt >> 1)};
  end

  function automatic logic [1:0] gray2(input int v);
    logic [1:0] b = v[1:0];
    return b ^ (b >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readSlot(input int slot);
    @(negedge clk);
    rdAddr = gray2(slot);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic clearSeq();
    nHits = 0; nTrig = 0;
    useTest = 0; testEnOn = 0; maskOn = 0;
  endtask

  // runs one hit/trigger sequence and checks every written slot
  task automatic runSeq(input string req);
    int acc[4];
    int nAcc = 0;
    bit effective = !maskOn && (!useTest || testEnOn);
    for (int h = 0; h < nHits; h++) begin
      int busy = 0;
      for (int a = 0; a < nAcc; a++)
        if (acc[a] >= hitAt[h] - PERIOD && acc[a] <= hitAt[h] - 1) busy++;
      if (effective && busy < NUNITS) begin
        acc[nAcc] = hitAt[h];
        nAcc++;
      end else if (effective) expOvf = 1'b1;
    end
    for (int t = 0; t < nTrig; t++) begin
      expBit[t] = 1'b0;
      for (int a = 0; a < nAcc; a++)
        if (acc[a] + PERIOD == trigAt[t]) expBit[t] = 1'b1;
    end
    cfgMask = maskOn;
    cfgTestEn = testEnOn;
    for (int c = 0; c <= RUNLEN; c++) begin
      bit isHit = 1'b0;
      bit isTrig = 1'b0;
      int slot = 0;
      @(negedge clk);
      for (int h = 0; h < nHits; h++) if (hitAt[h] == c) isHit = 1'b1;
      for (int t = 0; t < nTrig; t++) if (trigAt[t] == c) begin isTrig = 1'b1; slot = t; end
      discHit   = isHit && !useTest;
      testPulse = isHit && useTest;
      trigger   = isTrig;
      wrAddr    = gray2(slot);
    end
    @(negedge clk);
    discHit = 0; testPulse = 0; trigger = 0; cfgMask = 0; cfgTestEn = 0;
    for (int t = 0; t < nTrig; t++) begin
      readSlot(t);
      check(hitOut === expBit[t], req, hitOut, expBit[t]);
    end
    check(ovfFlag === expOvf, "R4 overflow flag", ovfFlag, expOvf);
  endtask

  task automatic testReset();
    check(hitOut === 1'b0, "R9 output after reset", hitOut, 0);
    check(ovfFlag === 1'b0, "R9 overflow after reset", ovfFlag, 0);
    for (int s = 0; s < 4; s++) begin
      readSlot(s);
      check(hitOut === 1'b0, "R9 entry cleared by reset", hitOut, 0);
    end
  endtask

  task automatic testBasic();
    clearSeq();
    hitAt[0] = 3; nHits = 1;
    trigAt[0] = 3 + PERIOD; nTrig = 1;
    runSeq("R1 R7 on-time trigger");
  endtask

  task automatic testOffsets();
    clearSeq();
    hitAt[0] = 2; nHits = 1;
    trigAt[0] = 1 + PERIOD; trigAt[1] = 2 + PERIOD; trigAt[2] = 3 + PERIOD; nTrig = 3;
    runSeq("R2 early/on-time/late trigger");
    // R8: output holds while the read address moves without a strobe
    readSlot(1);
    @(negedge clk);
    rdAddr = gray2(0);
    @(negedge clk);
    @(negedge clk);
    check(hitOut === 1'b1, "R8 output held without strobe", hitOut, 1);
  endtask

  task automatic testTwoHits();
    clearSeq();
    hitAt[0] = 0; hitAt[1] = 5; nHits = 2;
    trigAt[0] = PERIOD; trigAt[1] = PERIOD + 3; trigAt[2] = PERIOD + 5; nTrig = 3;
    runSeq("R3 two hits in one window");
  endtask

  task automatic testReuse();
    clearSeq();
    hitAt[0] = 0; hitAt[1] = 1; hitAt[2] = PERIOD + 1; nHits = 3;
    trigAt[0] = PERIOD; trigAt[1] = PERIOD + 1; trigAt[2] = 2 * PERIOD + 1; nTrig = 3;
    runSeq("R10 unit reused after expiry");
  endtask

  task automatic testPulseGate();
    clearSeq();
    useTest = 1; testEnOn = 0;
    hitAt[0] = 4; nHits = 1; trigAt[0] = 4 + PERIOD; nTrig = 1;
    runSeq("R6 test pulse without enable");
    clearSeq();
    useTest = 1; testEnOn = 1;
    hitAt[0] = 4; nHits = 1; trigAt[0] = 4 + PERIOD; nTrig = 1;
    runSeq("R6 test pulse with enable");
  endtask

  task automatic testMask();
    clearSeq();
    maskOn = 1;
    hitAt[0] = 4; nHits = 1; trigAt[0] = 4 + PERIOD; nTrig = 1;
    runSeq("R5 masked discriminator hit");
    clearSeq();
    maskOn = 1; useTest = 1; testEnOn = 1;
    hitAt[0] = 6; nHits = 1; trigAt[0] = 6 + PERIOD; nTrig = 1;
    runSeq("R5 masked test pulse");
  endtask

  task automatic testOverflow();
    clearSeq();
    hitAt[0] = 0; hitAt[1] = 1; hitAt[2] = PERIOD; nHits = 3;
    trigAt[0] = PERIOD; trigAt[1] = 2 * PERIOD; nTrig = 2;
    runSeq("R4 third hit dropped");
    testBasic();   // flag must stay set through later traffic
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    expOvf = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testOffsets();
    testTwoHits();
    testReuse();
    testPulseGate();
    testMask();
    testOverflow();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule